// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a register-mapped serial peripheral master. A host programs it over a simple 32-bit read/write strobe interface, queues words into a four-entry transmit buffer through a data port and collects the replies from a four-entry receive buffer through the same port. Every queued word goes out on the serial data output and produces exactly one captured word from the serial data input. Words are 8 or 16 bits long, sent most significant or least significant bit first, in any of the four clock polarity and phase combinations. The serial clock is the block clock divided by a programmable value plus one.

The controller has two operating modes. In configuration mode it never shifts, the serial clock rests at its idle level, the clocking register may be rewritten and the buffers may be cleared. In run mode it starts a word on its own whenever the transmit buffer holds data, unless a hold request is set. The host polls an idle flag before each burst, then waits either by polling or on an interrupt raised when the receive buffer reaches a programmed fill count. Chip selects are driven elsewhere.

The shifter is a four-state machine. `ENG_IDLE` waits; the transition *launch* (run mode, no hold, transmit data present, receive space free) pops a word and enters `ENG_FIRST_HALF`. The transition *mid-bit* (first half-period elapsed, input sampled) enters `ENG_SECOND_HALF`. From there *next-bit* returns to `ENG_FIRST_HALF` with the shift register advanced, or *last-bit* enters `ENG_STORE`, which pushes the received word and takes *retire* back to `ENG_IDLE`.

Top module: `spi_fm_ctrl`

## Requirements
- R1: After reset the mode register reads 0x40 (configuration), the clocking register reads 0x0108 (divider 1, 8-bit words), the status register reads 0x0004 (idle, both buffers empty), the serial clock is low and the interrupt is low.
- R2: Offsets are 0x00 mode, 0x04 shape, 0x08 clocking, 0x14 status, 0x18 data. The shape register holds polarity in bit 0, phase in bit 1, MSB-first in bit 2, receive interrupt enable in bit 9 and fill level minus one in bits 13:12, and reads back what was written to those bits; the clocking register holds the divider in bits 15:8 and the word length in bits 7:0.
- R3: A write to the clocking register takes effect only while mode bits 7:6 equal 01; otherwise it is ignored.
- R4: A write to the data port queues its low 16 bits; a write when four words are queued is dropped. Status bits 13:11 give the transmit occupancy.
- R5: A read of the data port with the receive buffer empty returns zero and leaves status bits 10:8 at zero.
- R6: Shifting starts only when mode bits 7:6 equal 10; in any other mode queued words stay queued and the serial clock holds the polarity level.
- R7: Each bit lasts n+1 clock cycles for divider n in 1..255; a divider of 0 acts as 1.
- R8: With phase 0 the input is sampled on the edge leaving the idle level and the output changes on the edge returning to it; with phase 1 the output changes on the edge leaving idle and the input is sampled on the return edge.
- R9: A word length value of 16 selects 16-bit words and any other value 8-bit words; MSB-first set sends bit L-1 first, clear sends bit 0 first, and received words are assembled in the same order.
- R10: Each transmitted word yields one received word, read back in order, with the receive occupancy in status bits 10:8; a word is not started while the receive buffer is full.
- R11: Status bit 14 is set while the receive occupancy is at least the programmed level plus one; the interrupt output is that bit gated by the enable in bit 9.
- R12: Writing the mode register with bits 7:6 = 01 and bit 0 = 1 empties both buffers.
- R13: Mode bit 1 set holds off new words in run mode; clearing it lets queued words go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider's base |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops data port) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive fill-level interrupt |

## Verification
On every cycle the assertions keep both buffer occupancies within depth, forbid a word from starting unless the previous cycle was in run mode without a hold, keep the clocking register frozen outside configuration mode, keep the idle serial clock at the polarity level and tie the interrupt to a non-empty receive buffer. Only the bench's scenarios can show that the bit sequence on the wire follows the selected length, order and phase, that the received words match a serial partner model, that the bit period follows the divider, and that clearing, dropping a push to a full buffer and the zero returned by an empty pop appear at the ports.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_CFG  = 2'b01,
        MODE_RUN  = 2'b10,
        MODE_RSVD = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FIRST_HALF,
        ENG_SECOND_HALF,
        ENG_STORE
    } eng_state_e;

    typedef struct packed {
        logic [1:0] rx_level;
        logic       rx_irq_en;
        logic       msb_first;
        logic       cpha;
        logic       cpol;
    } shape_t;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_SHAPE = 8'h04;
    localparam logic [7:0] OFS_CLK   = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_DATA  = 8'h18;

    localparam int NARROW_BITS = 8;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
    import spi_fm_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16,
    localparam int PER_W = DIV_W + 1,
    localparam int BC_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] load_word,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              msb_first,
    input  logic              wide,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              miso,
    output logic              take,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);

    eng_state_e        state;
    eng_state_e        nxt;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] shifted;
    logic [PER_W-1:0]  cnt;
    logic [PER_W-1:0]  period;
    logic [PER_W-1:0]  half_a;
    logic [PER_W-1:0]  half_b;
    logic [DIV_W-1:0]  n_eff;
    logic [BC_W-1:0]   bits_left;
    logic              samp;
    logic              half_end;
    logic              last_bit;
    logic              sclk_q;
    logic              lat_cpol;
    logic              lat_cpha;
    logic              lat_msb;
    logic              lat_wide;

    // bit cell of n+1 cycles split into two halves
    assign n_eff    = (div_n == '0) ? DIV_W'(1) : div_n;
    assign period   = {1'b0, n_eff} + PER_W'(1);
    assign half_b   = period >> 1;
    assign half_a   = period - half_b;
    assign half_end = (state == ENG_FIRST_HALF)  ? (cnt == half_a - PER_W'(1)) :
                      (state == ENG_SECOND_HALF) ? (cnt == half_b - PER_W'(1)) : 1'b0;
    assign last_bit = (bits_left == BC_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:        if (start)    nxt = ENG_FIRST_HALF;
            ENG_FIRST_HALF:  if (half_end) nxt = ENG_SECOND_HALF;
            ENG_SECOND_HALF: if (half_end) nxt = last_bit ? ENG_STORE : ENG_FIRST_HALF;
            ENG_STORE:                     nxt = ENG_IDLE;
        endcase
    end

    always_comb begin
        if (lat_msb) begin
            shifted = {sr[WORD_W-2:0], samp};
        end else begin
            shifted = sr >> 1;
            if (lat_wide) shifted[WORD_W-1]      = samp;
            else          shifted[NARROW_BITS-1] = samp;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            samp      <= 1'b0;
            cnt       <= '0;
            bits_left <= '0;
            sclk_q    <= 1'b0;
            lat_cpol  <= 1'b0;
            lat_cpha  <= 1'b0;
            lat_msb   <= 1'b0;
            lat_wide  <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    cnt    <= '0;
                    sclk_q <= cpol;
                    if (start) begin
                        sr        <= load_word;
                        bits_left <= wide ? BC_W'(WORD_W) : BC_W'(NARROW_BITS);
                        lat_cpol  <= cpol;
                        lat_cpha  <= cpha;
                        lat_msb   <= msb_first;
                        lat_wide  <= wide;
                        sclk_q    <= cpol ^ cpha;
                    end
                end
                ENG_FIRST_HALF: begin
                    if (half_end) begin
                        cnt    <= '0;
                        samp   <= miso;
                        sclk_q <= ~(lat_cpol ^ lat_cpha);
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                ENG_SECOND_HALF: begin
                    if (half_end) begin
                        cnt       <= '0;
                        sr        <= shifted;
                        bits_left <= bits_left - BC_W'(1);
                        sclk_q    <= last_bit ? lat_cpol : (lat_cpol ^ lat_cpha);
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                ENG_STORE: begin
                    sclk_q <= lat_cpol;
                end
            endcase
        end
    end

    assign take    = (state == ENG_IDLE) && start;
    assign done    = (state == ENG_STORE);
    assign busy    = (state != ENG_IDLE);
    assign sclk    = sclk_q;
    assign mosi    = lat_msb ? (lat_wide ? sr[WORD_W-1] : sr[NARROW_BITS-1]) : sr[0];
    assign rx_word = lat_wide ? sr : {{(WORD_W-NARROW_BITS){1'b0}}, sr[NARROW_BITS-1:0]};

endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
    import spi_fm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8,
    parameter int WORD_W     = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);

    op_mode_e          mode_q;
    logic              stop_q;
    shape_t            shape_q;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        len_q;

    logic              sel_mode, sel_shape, sel_clk, sel_stat, sel_data;
    logic              flush;
    logic              wide;
    logic              start;
    logic              take, done, busy;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] tx_head, rx_head;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              rx_hit;
    logic              idle;

    assign sel_mode  = (bus_addr == ADDR_W'(OFS_MODE));
    assign sel_shape = (bus_addr == ADDR_W'(OFS_SHAPE));
    assign sel_clk   = (bus_addr == ADDR_W'(OFS_CLK));
    assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));

    assign flush = bus_we && sel_mode && bus_wdata[0] && (bus_wdata[7:6] == MODE_CFG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_CFG;
            stop_q  <= 1'b0;
            shape_q <= '0;
            div_q   <= DIV_W'(1);
            len_q   <= 8'd8;
        end else if (bus_we) begin
            if (sel_mode) begin
                mode_q <= op_mode_e'(bus_wdata[7:6]);
                stop_q <= bus_wdata[1];
            end
            if (sel_shape) begin
                shape_q.cpol      <= bus_wdata[0];
                shape_q.cpha      <= bus_wdata[1];
                shape_q.msb_first <= bus_wdata[2];
                shape_q.rx_irq_en <= bus_wdata[9];
                shape_q.rx_level  <= bus_wdata[13:12];
            end
            if (sel_clk && mode_q == MODE_CFG) begin
                div_q <= bus_wdata[8 +: DIV_W];
                len_q <= bus_wdata[7:0];
            end
        end
    end

    assign wide  = (len_q == 8'd16);
    assign start = (mode_q == MODE_RUN) && !stop_q && !tx_empty && !rx_full;

    spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (bus_we && sel_data),
        .wdata (bus_wdata[WORD_W-1:0]),
        .pop   (take),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (done),
        .wdata (rx_word),
        .pop   (bus_re && sel_data),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_fm_shifter #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_word (tx_head),
        .cpol      (shape_q.cpol),
        .cpha      (shape_q.cpha),
        .msb_first (shape_q.msb_first),
        .wide      (wide),
        .div_n     (div_q),
        .miso      (miso),
        .take      (take),
        .done      (done),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy)
    );

    assign rx_hit = (rx_count >= (CW'(shape_q.rx_level) + CW'(1)));
    assign irq    = rx_hit && shape_q.rx_irq_en;
    assign idle   = !busy && tx_empty;

    always_comb begin
        bus_rdata = '0;
        if (sel_mode)  bus_rdata = {24'b0, mode_q, 4'b0, stop_q, 1'b0};
        if (sel_shape) bus_rdata = {18'b0, shape_q.rx_level, 2'b0, shape_q.rx_irq_en,
                                    6'b0, shape_q.msb_first, shape_q.cpha, shape_q.cpol};
        if (sel_clk)   bus_rdata = {16'b0, 8'(div_q), len_q};
        if (sel_stat)  bus_rdata = {17'b0, rx_hit, 3'(tx_count), 3'(rx_count), 5'b0, idle, 2'b0};
        if (sel_data)  bus_rdata = {16'b0, 16'(rx_head)};
    end

endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk
    import spi_fm_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk,
    input logic          cpol,
    input logic          busy,
    input op_mode_e      mode,
    input logic          stop,
    input logic [15:0]   ctrl1,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          irq
);

    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH)); // R4

    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH)); // R10

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(mode) == MODE_RUN)); // R6

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(stop)); // R13

    AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol)); // R6

    AST_CLOCKING_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) != MODE_CFG) |-> $stable(ctrl1)); // R3

    AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_cnt != '0)); // R11

endmodule

bind spi_fm_ctrl spi_fm_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .cpol   (shape_q.cpol),
    .busy   (busy),
    .mode   (mode_q),
    .stop   (stop_q),
    .ctrl1  ({8'(div_q), len_q}),
    .tx_cnt (tx_count),
    .rx_cnt (rx_count),
    .irq    (irq)
);

// File: tb/sim_spi_fm_ctrl.sv
module sim_spi_fm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    spi_fm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    // serial partner model: shifts its stream on return-to-idle edges
    logic [63:0] s_out = '0;
    logic [63:0] s_cap = '0;
    logic        s_cpol = 1'b0;
    logic        s_cpha = 1'b0;
    int          last_rise = 0;
    int          prev_rise = 0;

    assign miso = s_out[63];

    always @(sclk) begin
        if (sclk != s_cpol) begin
            if (!s_cpha) s_cap <= {s_cap[62:0], mosi};
        end else begin
            if (s_cpha) s_cap <= {s_cap[62:0], mosi};
            s_out <= s_out << 1;
        end
    end

    always @(posedge sclk) begin
        prev_rise = last_rise;
        last_rise = cyc;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_rx(input int words);
        logic [31:0] st;
        for (int k = 0; k < 4000; k++) begin
            bus_rd(8'h14, st);
            if (st[2] && st[10:8] == 3'(words)) break;
        end
    endtask

    function automatic logic [15:0] rev(input logic [15:0] x, input int len);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < len; i++) r[i] = x[len-1-i];
        return r;
    endfunction

    function automatic logic [15:0] wmask(input int len);
        return (len == 16) ? 16'hFFFF : 16'h00FF;
    endfunction

    // one full burst against the partner model
    task automatic run_burst(input bit cpol, input bit cpha, input bit msb, input bit wide,
                             input int n, input int cnt,
                             input logic [15:0] tw [4], input logic [15:0] sw [4], input string tag);
        int len;
        logic [63:0] exp_cap;
        logic [63:0] cmask;
        logic [31:0] d;
        logic [15:0] er;
        len = wide ? 16 : 8;
        bus_wr(8'h00, 32'h41);
        bus_wr(8'h04, {29'b0, msb, cpha, cpol});
        bus_wr(8'h08, {16'b0, 8'(n), wide ? 8'd16 : 8'd8});
        repeat (2) @(negedge clk);
        s_cpol = cpol; s_cpha = cpha;
        s_out = '0; s_cap = '0; exp_cap = '0;
        for (int i = 0; i < cnt; i++) begin
            s_out = (s_out << len) | 64'(sw[i] & wmask(len));
            exp_cap = (exp_cap << len) | 64'(msb ? (tw[i] & wmask(len)) : rev(tw[i] & wmask(len), len));
        end
        s_out = s_out << (64 - cnt * len);
        cmask = (cnt * len == 64) ? '1 : ((64'd1 << (cnt * len)) - 64'd1);
        for (int i = 0; i < cnt; i++) bus_wr(8'h18, {16'b0, tw[i]});
        bus_wr(8'h00, 32'h80);
        wait_rx(cnt);
        for (int i = 0; i < cnt; i++) begin
            bus_rd(8'h18, d);
            er = msb ? (sw[i] & wmask(len)) : rev(sw[i] & wmask(len), len);
            check(d[15:0] == er, {tag, " R8 R10 rx word"}, 64'(d[15:0]), 64'(er));
        end
        check((s_cap & cmask) == exp_cap, {tag, " R9 wire bit sequence"}, s_cap & cmask, exp_cap);
        bus_wr(8'h00, 32'h40);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic [15:0] tw [4];
        logic [15:0] sw [4];
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(8'h00, d); check(d == 32'h40, "R1 mode reg", 64'(d), 64'h40);
        bus_rd(8'h08, d); check(d == 32'h0108, "R1 clocking reg", 64'(d), 64'h0108);
        bus_rd(8'h14, d); check(d == 32'h0004, "R1 status reg", 64'(d), 64'h4);
        check(sclk == 1'b0 && irq == 1'b0, "R1 sclk/irq low", {62'b0, sclk, irq}, 64'h0);

        // R2 readback
        bus_wr(8'h04, 32'h3207);
        bus_rd(8'h04, d); check(d == 32'h3207, "R2 shape readback", 64'(d), 64'h3207);
        bus_wr(8'h08, 32'h0510);
        bus_rd(8'h08, d); check(d == 32'h0510, "R2 clocking readback", 64'(d), 64'h0510);

        // R3 clocking write ignored in run mode
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h00, 32'h80);
        bus_wr(8'h08, 32'h0A08);
        bus_rd(8'h08, d); check(d == 32'h0510, "R3 clocking locked", 64'(d), 64'h0510);
        bus_wr(8'h00, 32'h40);
        bus_wr(8'h08, 32'h0108);

        // R4 / R6 queueing in configuration mode, fifth push dropped
        for (int i = 0; i < 5; i++) bus_wr(8'h18, 32'h11 * (i + 1));
        bus_rd(8'h14, d); check(d[13:11] == 3'd4, "R4 tx occupancy capped", 64'(d[13:11]), 64'd4);
        repeat (40) @(negedge clk);
        bus_rd(8'h14, d); check(d[13:11] == 3'd4 && d[10:8] == 3'd0, "R6 no shift in config", 64'(d[13:8]), 64'h20);
        check(sclk == 1'b0, "R6 sclk at idle level", 64'(sclk), 64'h0);

        // R12 clear
        bus_wr(8'h00, 32'h41);
        bus_rd(8'h14, d); check(d == 32'h0004, "R12 clear empties buffers", 64'(d), 64'h4);

        // R5 empty pop
        bus_rd(8'h18, d); check(d == 32'h0, "R5 empty pop returns zero", 64'(d), 64'h0);
        bus_rd(8'h14, d); check(d[10:8] == 3'd0, "R5 rx occupancy unchanged", 64'(d[10:8]), 64'h0);

        // R13 hold request
        bus_wr(8'h00, 32'h82);
        bus_wr(8'h18, 32'h5A);
        repeat (40) @(negedge clk);
        bus_rd(8'h14, d); check(d[13:11] == 3'd1 && d[10:8] == 3'd0, "R13 held while stop set", 64'(d[13:8]), 64'h08);
        bus_wr(8'h00, 32'h80);
        wait_rx(1);
        bus_rd(8'h14, d); check(d[13:11] == 3'd0 && d[10:8] == 3'd1, "R13 released", 64'(d[13:8]), 64'h01);
        bus_wr(8'h00, 32'h41);

        // R7 bit period
        tw = '{16'hA5, 16'h0, 16'h0, 16'h0}; sw = '{16'h3C, 16'h0, 16'h0, 16'h0};
        run_burst(1'b0, 1'b0, 1'b1, 1'b0, 3, 1, tw, sw, "period n=3");
        check(last_rise - prev_rise == 4, "R7 period n=3", 64'(last_rise - prev_rise), 64'd4);
        run_burst(1'b0, 1'b1, 1'b1, 1'b0, 0, 1, tw, sw, "period n=0");
        check(last_rise - prev_rise == 2, "R7 period n=0 acts as 1", 64'(last_rise - prev_rise), 64'd2);

        // R9 directed: 16-bit, LSB first, polarity 1, phase 1
        tw = '{16'h8001, 16'h1234, 16'h0, 16'h0}; sw = '{16'hC003, 16'hBEEF, 16'h0, 16'h0};
        run_burst(1'b1, 1'b1, 1'b0, 1'b1, 2, 2, tw, sw, "R9 wide lsb");

        // R11 fill-level flag and interrupt
        bus_wr(8'h00, 32'h41);
        bus_wr(8'h04, 32'h1000);
        bus_wr(8'h18, 32'h01);
        bus_wr(8'h18, 32'h02);
        bus_wr(8'h00, 32'h80);
        wait_rx(2);
        bus_rd(8'h14, d); check(d[14] == 1'b1 && irq == 1'b0, "R11 level hit, irq disabled", {62'b0, d[14], irq}, 64'h2);
        bus_wr(8'h04, 32'h1200);
        @(negedge clk); check(irq == 1'b1, "R11 irq raised", 64'(irq), 64'h1);
        bus_rd(8'h18, d);
        @(negedge clk); check(irq == 1'b0, "R11 irq drops below level", 64'(irq), 64'h0);
        bus_rd(8'h14, d); check(d[14] == 1'b0, "R11 level flag clears", 64'(d[14]), 64'h0);
        bus_wr(8'h00, 32'h41);

        // constrained random bursts
        for (int it = 0; it < 24; it++) begin
            int cnt;
            for (int i = 0; i < 4; i++) begin
                tw[i] = 16'($urandom);
                sw[i] = 16'($urandom);
            end
            cnt = int'($urandom_range(1, 4));
            run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom_range(0, 3)), cnt, tw, sw, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule